// File: doc/BRIEF.md
# Privilege-Gated Performance Counter Bank

This block holds the hardware performance counters of a processor core: one cycle counter, one retired-instruction counter, sixteen general event counters and four counters for second-level cache events. Each counter is 64 bits wide. A counter advances by one on any clock edge where its event pulse is high and its enable is high. Software can load any counter through a single write port.

Counting can be switched off per privilege level. There is one disable bit for each of the three modes: user, supervisor and machine. When the bit that belongs to the current mode is set, every counter stops. This inhibit is decoded combinationally from the current mode and the disable bits, so it takes effect on the same cycle the mode changes. A registered copy of the inhibit is used only to keep the clock-gate request high across a transition. The enables are also driven out, so that event sources can suppress work that nobody counts. One further enable is exported for external event logic.

Top module: `pcb_bank`

## Requirements
- R1: During and after reset every counter reads zero and no overflow pulse is high. The registered inhibit copy resets to "inhibited", so on the first cycle after reset in an enabled mode `clk_req` is high even when no counter is enabled.
- R2: Privilege encoding on `priv_mode` is user 2'b00, supervisor 2'b01, machine 2'b11. The value 2'b10 is reserved and is always inhibited. When the disable bit of the current mode is set (`dis_u`, `dis_s` or `dis_m`), no counter changes unless it is written.
- R3: The inhibit follows `priv_mode` in the same cycle. On the first cycle in a disabled mode no counter increments, and on the first cycle back in an enabled mode counting resumes.
- R4: `cnt_en[i]` equals `glb_en AND NOT inhibit AND NOT cnt_mask[i]`. `ext_cnt_en` equals `glb_en AND NOT inhibit`.
- R5: Counter i (index 0 is cycle, 1 is instret, 2 to 17 are events, 18 to 21 are cache events) appears at `cnt_val[64*i +: 64]`. It increments by one after an edge where `cnt_en[i]` and `evt_pulse[i]` are both high, and holds otherwise.
- R6: When `wr_en` is high, counter `wr_idx` loads `wr_data` exactly on that edge. The load takes priority over an increment in the same cycle. Indices 22 to 31 write nothing.
- R7: An increment from all ones wraps to zero. `ovf_pulse[i]` is high for exactly the one cycle in which the wrapped zero is shown. A write never raises it.
- R8: `clk_req` is high whenever any `cnt_en` bit is high, or `wr_en` is high, or the combinational inhibit differs from its registered copy of the previous edge.
- R9: Setting `cnt_mask[i]` blocks counter i alone (an OR with the privilege inhibit). Other counters are unaffected.
- R10: With `glb_en` low, all 22 enables and `ext_cnt_en` are low, and no counter increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_mode | input | 2 | Current privilege mode |
| dis_m | input | 1 | Inhibit counting in machine mode |
| dis_s | input | 1 | Inhibit counting in supervisor mode |
| dis_u | input | 1 | Inhibit counting in user mode |
| glb_en | input | 1 | Global counting enable |
| cnt_mask | input | 22 | Per-counter inhibit |
| evt_pulse | input | 22 | Per-counter event pulse |
| wr_en | input | 1 | Software write strobe |
| wr_idx | input | 5 | Counter selected for the write |
| wr_data | input | 64 | Value to load |
| cnt_val | output | 1408 | Counter values, 64 bits per counter |
| ovf_pulse | output | 22 | Per-counter wrap pulse |
| cnt_en | output | 22 | Per-counter enables |
| ext_cnt_en | output | 1 | Enable exported to external event logic |
| clk_req | output | 1 | Clock-gate request |

## Verification
Two pairs of events can fall in the same cycle. The first is a software write and an increment of the same counter. The second is a privilege change into a disabled mode and a burst of event pulses. Both are provoked by directed steps: a write of all ones with the event high, a write to a counter whose event is high, and a switch from user to a disabled machine mode with every event asserted. Random stimulus then mixes writes, mode changes and masks on every cycle. A bench model of the counters judges each edge: it lets the write win, it drops every event on the cycle of the mode change, and it resumes counting on the return cycle.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;

  // Combinational per-mode inhibit; the reserved encoding never counts.
  function automatic logic mode_inhibited(input logic [1:0] mode,
                                          input logic dm,
                                          input logic ds,
                                          input logic du);
    logic res;
    case (priv_e'(mode))
      PRIV_M:  res = dm;
      PRIV_S:  res = ds;
      PRIV_U:  res = du;
      default: res = 1'b1;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/pcb_inhibit.sv
module pcb_inhibit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] priv_mode,
  input  logic       dis_m,
  input  logic       dis_s,
  input  logic       dis_u,
  output logic       inh_now,
  output logic       inh_reg
);

  always_comb begin
    inh_now = pcb_pkg::mode_inhibited(priv_mode, dis_m, dis_s, dis_u);
  end

  // Registered copy feeds only the clock-gate term; reset to inhibited.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inh_reg <= 1'b1;
    else        inh_reg <= inh_now;
  end

endmodule

// File: rtl/pcb_enable.sv
module pcb_enable #(
  parameter int NCNT = 22
) (
  input  logic            glb_en,
  input  logic            inh_now,
  input  logic [NCNT-1:0] cnt_mask,
  output logic [NCNT-1:0] cnt_en,
  output logic            ext_cnt_en
);

  logic open_gate;

  assign open_gate  = glb_en & ~inh_now;
  assign ext_cnt_en = open_gate;

  for (genvar g = 0; g < NCNT; g++) begin : g_en
    assign cnt_en[g] = open_gate & ~cnt_mask[g];
  end

endmodule

// File: rtl/pcb_counter.sv
module pcb_counter #(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_i,
  input  logic          wr_i,
  input  logic [CW-1:0] wr_data_i,
  output logic [CW-1:0] val_o,
  output logic          ovf_o
);

  localparam logic [CW-1:0] ALL_ONES = '1;

  logic at_top;

  assign at_top = (val_o == ALL_ONES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_o <= '0;
      ovf_o <= 1'b0;
    end else begin
      ovf_o <= inc_i & ~wr_i & at_top;
      if (wr_i)       val_o <= wr_data_i;
      else if (inc_i) val_o <= val_o + 1'b1;
    end
  end

endmodule

// File: rtl/pcb_clkreq.sv
module pcb_clkreq #(
  parameter int NCNT = 22
) (
  input  logic [NCNT-1:0] cnt_en,
  input  logic            wr_en,
  input  logic            inh_now,
  input  logic            inh_reg,
  output logic            clk_req
);

  assign clk_req = (|cnt_en) | wr_en | (inh_now ^ inh_reg);

endmodule

// File: rtl/pcb_bank.sv
module pcb_bank #(
  parameter  int CW    = 64,
  parameter  int N_EVT = 16,
  parameter  int N_L2  = 4,
  localparam int NCNT  = 2 + N_EVT + N_L2,
  localparam int IW    = $clog2(NCNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       priv_mode,
  input  logic             dis_m,
  input  logic             dis_s,
  input  logic             dis_u,
  input  logic             glb_en,
  input  logic [NCNT-1:0]  cnt_mask,
  input  logic [NCNT-1:0]  evt_pulse,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [CW-1:0]    wr_data,
  output logic [NCNT*CW-1:0] cnt_val,
  output logic [NCNT-1:0]  ovf_pulse,
  output logic [NCNT-1:0]  cnt_en,
  output logic             ext_cnt_en,
  output logic             clk_req
);

  logic inh_now;
  logic inh_reg;

  pcb_inhibit u_inhibit (
    .clk       (clk),
    .rst_n     (rst_n),
    .priv_mode (priv_mode),
    .dis_m     (dis_m),
    .dis_s     (dis_s),
    .dis_u     (dis_u),
    .inh_now   (inh_now),
    .inh_reg   (inh_reg)
  );

  pcb_enable #(.NCNT(NCNT)) u_enable (
    .glb_en     (glb_en),
    .inh_now    (inh_now),
    .cnt_mask   (cnt_mask),
    .cnt_en     (cnt_en),
    .ext_cnt_en (ext_cnt_en)
  );

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    logic inc;
    logic hit;
    assign inc = cnt_en[g] & evt_pulse[g];
    assign hit = wr_en & (wr_idx == IW'(g));
    pcb_counter #(.CW(CW)) u_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_i     (inc),
      .wr_i      (hit),
      .wr_data_i (wr_data),
      .val_o     (cnt_val[g*CW +: CW]),
      .ovf_o     (ovf_pulse[g])
    );
  end

  pcb_clkreq #(.NCNT(NCNT)) u_clkreq (
    .cnt_en  (cnt_en),
    .wr_en   (wr_en),
    .inh_now (inh_now),
    .inh_reg (inh_reg),
    .clk_req (clk_req)
  );

endmodule

// File: rtl/pcb_bank_chk.sv
module pcb_bank_chk #(
  parameter int CW   = 64,
  parameter int NCNT = 22,
  parameter int IW   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         priv_mode,
  input logic               dis_m,
  input logic               dis_s,
  input logic               dis_u,
  input logic               glb_en,
  input logic [NCNT-1:0]    cnt_mask,
  input logic               wr_en,
  input logic [IW-1:0]      wr_idx,
  input logic [CW-1:0]      wr_data,
  input logic [NCNT*CW-1:0] cnt_val,
  input logic [NCNT-1:0]    ovf_pulse,
  input logic [NCNT-1:0]    cnt_en,
  input logic               ext_cnt_en,
  input logic               clk_req
);

  logic mode_off;
  assign mode_off = (priv_mode == 2'b10) ||
                    (priv_mode == 2'b11 && dis_m) ||
                    (priv_mode == 2'b01 && dis_s) ||
                    (priv_mode == 2'b00 && dis_u);

  // R2 R3
  held_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_off && !wr_en) |=> $stable(cnt_val));

  // R10
  glb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> (cnt_en == '0 && !ext_cnt_en));

  // R8
  clk_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cnt_en) || wr_en) |-> clk_req);

  // R4
  ext_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cnt_en |-> ((cnt_en | cnt_mask) == '1));

  for (genvar k = 0; k < NCNT; k++) begin : g_chk
    // R7
    ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse[k] |-> (cnt_val[k*CW +: CW] == '0));
    // R6
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IW'(k)) |=> (cnt_val[k*CW +: CW] == $past(wr_data)));
    // R9
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_mask[k] |-> !cnt_en[k]);
  end

endmodule

bind pcb_bank pcb_bank_chk #(.CW(CW), .NCNT(NCNT), .IW(IW)) u_pcb_bank_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .priv_mode  (priv_mode),
  .dis_m      (dis_m),
  .dis_s      (dis_s),
  .dis_u      (dis_u),
  .glb_en     (glb_en),
  .cnt_mask   (cnt_mask),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_data    (wr_data),
  .cnt_val    (cnt_val),
  .ovf_pulse  (ovf_pulse),
  .cnt_en     (cnt_en),
  .ext_cnt_en (ext_cnt_en),
  .clk_req    (clk_req)
);

// File: tb/test_pcb_bank.sv
module test_pcb_bank;

  localparam int CLK_PERIOD = 10;
  localparam int CW   = 64;
  localparam int NCNT = 22;
  localparam int IW   = 5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       priv_mode;
  logic             dis_m, dis_s, dis_u, glb_en;
  logic [NCNT-1:0]  cnt_mask, evt_pulse;
  logic             wr_en;
  logic [IW-1:0]    wr_idx;
  logic [CW-1:0]    wr_data;
  logic [NCNT*CW-1:0] cnt_val;
  logic [NCNT-1:0]  ovf_pulse, cnt_en;
  logic             ext_cnt_en, clk_req;

  int n_chk = 0;
  int n_err = 0;

  logic [CW-1:0]   m_val [NCNT];
  logic [NCNT-1:0] m_ovf;
  logic [NCNT-1:0] m_en;
  logic            m_inh_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcb_bank i_pcb_bank (
    .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode),
    .dis_m(dis_m), .dis_s(dis_s), .dis_u(dis_u), .glb_en(glb_en),
    .cnt_mask(cnt_mask), .evt_pulse(evt_pulse), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .cnt_val(cnt_val),
    .ovf_pulse(ovf_pulse), .cnt_en(cnt_en), .ext_cnt_en(ext_cnt_en),
    .clk_req(clk_req)
  );

  function automatic logic exp_inh(input logic [1:0] p, input logic dm,
                                   input logic ds, input logic du);
    if (p == 2'b11) return dm;
    if (p == 2'b01) return ds;
    if (p == 2'b00) return du;
    return 1'b1;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Inputs are already driven (just after a negedge). Checks combinational
  // outputs, lets one edge pass, updates the model, checks registered outputs.
  task automatic step(input string tag);
    logic inh;
    logic exp_req;
    #1;
    inh = exp_inh(priv_mode, dis_m, dis_s, dis_u);
    for (int i = 0; i < NCNT; i++) m_en[i] = glb_en & ~inh & ~cnt_mask[i];
    exp_req = (|m_en) | wr_en | (inh ^ m_inh_q);
    chk(cnt_en == m_en, {tag, " R4 cnt_en"}, CW'(cnt_en), CW'(m_en));
    chk(ext_cnt_en == (glb_en & ~inh), {tag, " R4 ext_cnt_en"},
        CW'(ext_cnt_en), CW'(glb_en & ~inh));
    chk(clk_req == exp_req, {tag, " R8 clk_req"}, CW'(clk_req), CW'(exp_req));
    @(posedge clk);
    for (int i = 0; i < NCNT; i++) begin
      logic inc, hit;
      inc = m_en[i] & evt_pulse[i];
      hit = wr_en && (wr_idx == IW'(i));
      m_ovf[i] = inc & ~hit & (m_val[i] == '1);
      if (hit)      m_val[i] = wr_data;
      else if (inc) m_val[i] = m_val[i] + 1'b1;
    end
    m_inh_q = inh;
    @(negedge clk);
    for (int i = 0; i < NCNT; i++)
      chk(cnt_val[i*CW +: CW] == m_val[i], {tag, " counter"},
          cnt_val[i*CW +: CW], m_val[i]);
    chk(ovf_pulse == m_ovf, {tag, " R7 ovf_pulse"}, CW'(ovf_pulse), CW'(m_ovf));
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    evt_pulse = '0; cnt_mask = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    priv_mode = 2'b11; dis_m = 1'b0; dis_s = 1'b0; dis_u = 1'b0;
    glb_en = 1'b0;
    idle_inputs();
    for (int i = 0; i < NCNT; i++) m_val[i] = '0;
    m_ovf = '0; m_en = '0; m_inh_q = 1'b1;
    repeat (3) @(negedge clk);
    // R1: values during reset
    for (int i = 0; i < NCNT; i++)
      chk(cnt_val[i*CW +: CW] == '0, "R1 reset value", cnt_val[i*CW +: CW], '0);
    chk(ovf_pulse == '0, "R1 reset ovf", CW'(ovf_pulse), '0);
    rst_n = 1'b1;
    #1;
    // R1: registered inhibit starts inhibited, so a transition is pending
    chk(clk_req == 1'b1, "R1 clk_req after reset", CW'(clk_req), 1);
    step("R1");
    step("R1");

    // R10: global enable low blocks every counter
    evt_pulse = '1;
    step("R10");
    step("R10");

    // R2: each mode with its own disable bit set, and the reserved mode
    glb_en = 1'b1;
    priv_mode = 2'b00; dis_u = 1'b1; step("R2");
    dis_u = 1'b0; step("R2");
    priv_mode = 2'b01; dis_s = 1'b1; step("R2");
    dis_s = 1'b0; step("R2");
    priv_mode = 2'b11; dis_m = 1'b1; step("R2");
    dis_m = 1'b0; step("R2");
    priv_mode = 2'b10; step("R2 reserved");
    dis_u = 1'b1; dis_s = 1'b1; priv_mode = 2'b11; step("R2 other bits");
    dis_u = 1'b0; dis_s = 1'b0;

    // R3: enter and leave a disabled mode with events on every cycle
    dis_m = 1'b1; priv_mode = 2'b00; step("R3");
    priv_mode = 2'b11; step("R3 entry");
    step("R3");
    priv_mode = 2'b00; step("R3 exit");
    step("R3");

    // R9: mask alternate counters
    cnt_mask = 22'h2AAAAA; step("R9"); step("R9");
    cnt_mask = '0;

    // R6: write wins over a same-cycle increment; invalid index writes nothing
    wr_en = 1'b1; wr_idx = 5'd5; wr_data = 64'h0123_4567_89AB_CDEF;
    step("R6 write vs inc");
    wr_idx = 5'd22; wr_data = 64'hDEAD_BEEF_0000_0001; step("R6 idx 22");
    wr_idx = 5'd31; step("R6 idx 31");

    // R7: wrap and one-cycle overflow pulse; write of all ones raises none
    evt_pulse = '0;
    wr_idx = 5'd0; wr_data = '1; step("R7 preload");
    wr_en = 1'b0; evt_pulse[0] = 1'b1; step("R7 wrap");
    step("R7 pulse clears");
    wr_en = 1'b1; wr_idx = 5'd21; wr_data = '1; evt_pulse = '1;
    step("R7 write beats wrap");
    wr_en = 1'b0; evt_pulse = 22'h200000; step("R7 wrap 21");
    evt_pulse = '0; step("R7");

    // R5: constrained random mix
    for (int c = 0; c < 2000; c++) begin
      priv_mode = 2'($urandom);
      dis_m = ($urandom_range(0, 3) == 0);
      dis_s = ($urandom_range(0, 3) == 0);
      dis_u = ($urandom_range(0, 3) == 0);
      glb_en = ($urandom_range(0, 9) != 0);
      cnt_mask = ($urandom_range(0, 3) == 0) ? NCNT'($urandom) : '0;
      evt_pulse = NCNT'($urandom);
      wr_en = ($urandom_range(0, 7) == 0);
      wr_idx = IW'($urandom);
      wr_data = ($urandom_range(0, 3) == 0) ? {CW{1'b1}} - CW'($urandom_range(0, 2))
                                              : {$urandom, $urandom};
      step("R5");
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule